// File: doc/BRIEF.md
# Streaming Expected-Value Checker

This block watches one data signal and compares it, once per clock, against a list of expected values that is fixed when the design is built. The list has `LEN` entries and is packed into the parameter `EXP_LIST`. Entry `i` occupies bits `[i*DATA_W +: DATA_W]`, so entry 0 sits in the least significant bits. After reset the block steps through the list, one entry per clock. When the list runs out, it keeps comparing against the final entry.

Any inequality produces a one-cycle strobe. The same strobe loads a report: the cycle number counted from reset, the expected value and the observed value. A sticky error flag records that at least one mismatch has occurred. A done flag shows that every entry has been applied, whatever the comparisons found. A bench or a built-in self test can read pass or fail from `err_seen` and `done` alone, with no text output.

The cycle numbering works as follows. Reset is synchronous and active high. The first rising edge after reset is released closes cycle 0. During cycle `k`, `data_in` is held, and the edge at the end of cycle `k` evaluates it.

Top module: `stream_checker`

## Requirements
- R1: After one or more clock edges with `rst` high, `done`, `mismatch` and `err_seen` are 0, and `rpt_cycle`, `rpt_expected` and `rpt_actual` are all 0.
- R2: In cycle `k < LEN`, `data_in` is compared with entry `k` of `EXP_LIST`. Entry `i` is `EXP_LIST[i*DATA_W +: DATA_W]`.
- R3: `mismatch` is high during cycle `k+1` exactly when `data_in` differed from the expected entry in cycle `k`. In every other case it is low.
- R4: On a mismatch in cycle `k`, cycle `k+1` shows `rpt_cycle = k`, the expected value in `rpt_expected` and `data_in` in `rpt_actual`. All three hold their values until the next mismatch or reset.
- R5: `err_seen` goes high in the cycle after the first mismatch and stays high until reset.
- R6: `done` is low in cycles 0 to `LEN-1` and high from cycle `LEN` until reset. Whether comparisons matched has no effect on it.
- R7: In every cycle `k >= LEN`, `data_in` is compared with entry `LEN-1`.
- R8: A reset applied in the middle of a run restarts the cycle count and the list index at 0 and clears `done`, `err_seen` and the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Checking clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | DATA_W | Monitored value, one sample per cycle |
| done | output | 1 | All list entries applied; held until reset |
| mismatch | output | 1 | One-cycle strobe for a mismatch in the previous cycle |
| err_seen | output | 1 | Sticky flag, set by any mismatch |
| rpt_cycle | output | CYC_W | Cycle number of the latest mismatch |
| rpt_expected | output | DATA_W | Expected value of the latest mismatch |
| rpt_actual | output | DATA_W | Observed value of the latest mismatch |

## Verification
`done` belongs to the current cycle. It is checked while cycle `k` is still in progress, before the edge that closes that cycle. `mismatch`, `err_seen` and the three report fields come from registers that the closing edge loads. They are due one cycle late and are sampled on the falling edge after that closing edge. The reference model in the bench computes the expected entry from its own cycle count. It predicts each registered result one cycle ahead and compares it at that falling edge.

// File: rtl/stream_chk_pkg.sv
package stream_chk_pkg;

    // Sequencer phase: walking the list, or parked on its final entry.
    typedef enum logic {
        SEQ_WALK  = 1'b0,
        SEQ_PARKED = 1'b1
    } seq_phase_e;

    // Width of an index into a list of n entries (at least one bit).
    function automatic int index_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Registered result of one comparison.
    typedef struct packed {
        logic hit;
        logic seen;
    } cmp_flags_t;

endpackage

// File: rtl/chk_sequencer.sv
module chk_sequencer #(
    parameter int LEN   = 10,
    parameter int CYC_W = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx,
    output logic [CYC_W-1:0] cyc,
    output logic             done
);
    import stream_chk_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LEN - 1);

    seq_phase_e       phase_q;
    logic [IDX_W-1:0] idx_q;
    logic [CYC_W-1:0] cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SEQ_WALK;
            idx_q   <= '0;
        end else if (phase_q == SEQ_WALK) begin
            if (idx_q == LAST_IDX) begin
                phase_q <= SEQ_PARKED;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign idx  = idx_q;
    assign cyc  = cyc_q;
    assign done = (phase_q == SEQ_PARKED);
endmodule

// File: rtl/chk_ref_table.sv
module chk_ref_table #(
    parameter int                      DATA_W   = 8,
    parameter int                      LEN      = 10,
    parameter int                      IDX_W    = 4,
    parameter logic [LEN*DATA_W-1:0]   EXP_LIST = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] exp_val
);
    logic [DATA_W-1:0] entries [LEN];

    generate
        for (genvar g = 0; g < LEN; g++) begin : g_entry
            assign entries[g] = EXP_LIST[g*DATA_W +: DATA_W];
        end
    endgenerate

    always_comb begin
        exp_val = entries[0];
        for (int i = 0; i < LEN; i++) begin
            if (idx == IDX_W'(i)) begin
                exp_val = entries[i];
            end
        end
    end
endmodule

// File: rtl/chk_compare.sv
module chk_compare #(
    parameter int DATA_W = 8,
    parameter int CYC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] exp_val,
    input  logic [CYC_W-1:0]  cyc,
    output logic              mismatch,
    output logic              err_seen,
    output logic [CYC_W-1:0]  rpt_cycle,
    output logic [DATA_W-1:0] rpt_expected,
    output logic [DATA_W-1:0] rpt_actual
);
    import stream_chk_pkg::*;

    logic              differ;
    cmp_flags_t        flags_q;
    logic [CYC_W-1:0]  cyc_q;
    logic [DATA_W-1:0] exp_q;
    logic [DATA_W-1:0] act_q;

    assign differ = (data_in != exp_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.hit  <= differ;
            flags_q.seen <= flags_q.seen | differ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
            exp_q <= '0;
            act_q <= '0;
        end else if (differ) begin
            cyc_q <= cyc;
            exp_q <= exp_val;
            act_q <= data_in;
        end
    end

    assign mismatch     = flags_q.hit;
    assign err_seen     = flags_q.seen;
    assign rpt_cycle    = cyc_q;
    assign rpt_expected = exp_q;
    assign rpt_actual   = act_q;
endmodule

// File: rtl/stream_checker.sv
module stream_checker #(
    parameter int                    DATA_W   = 8,
    parameter int                    LEN      = 10,
    parameter int                    CYC_W    = 16,
    parameter logic [LEN*DATA_W-1:0] EXP_LIST = {8'd10, 8'd9, 8'd8, 8'd7, 8'd5,
                                                 8'd4, 8'd3, 8'd2, 8'd99, 8'd70}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    output logic              done,
    output logic              mismatch,
    output logic              err_seen,
    output logic [CYC_W-1:0]  rpt_cycle,
    output logic [DATA_W-1:0] rpt_expected,
    output logic [DATA_W-1:0] rpt_actual
);
    localparam int IDX_W = stream_chk_pkg::index_width(LEN);

    logic [IDX_W-1:0]  cur_idx;
    logic [CYC_W-1:0]  cur_cyc;
    logic [DATA_W-1:0] cur_exp;

    chk_sequencer #(.LEN(LEN), .CYC_W(CYC_W), .IDX_W(IDX_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .idx  (cur_idx),
        .cyc  (cur_cyc),
        .done (done)
    );

    chk_ref_table #(.DATA_W(DATA_W), .LEN(LEN), .IDX_W(IDX_W), .EXP_LIST(EXP_LIST)) u_tbl (
        .idx     (cur_idx),
        .exp_val (cur_exp)
    );

    chk_compare #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_cmp (
        .clk          (clk),
        .rst          (rst),
        .data_in      (data_in),
        .exp_val      (cur_exp),
        .cyc          (cur_cyc),
        .mismatch     (mismatch),
        .err_seen     (err_seen),
        .rpt_cycle    (rpt_cycle),
        .rpt_expected (rpt_expected),
        .rpt_actual   (rpt_actual)
    );
endmodule

// File: rtl/stream_checker_sva.sv
module stream_checker_sva #(
    parameter int DATA_W = 8,
    parameter int LEN    = 10,
    parameter int CYC_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              mismatch,
    input logic              err_seen,
    input logic [CYC_W-1:0]  cyc_now,
    input logic [CYC_W-1:0]  rpt_cycle,
    input logic [DATA_W-1:0] rpt_expected,
    input logic [DATA_W-1:0] rpt_actual
);
    p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_done_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cyc_now == CYC_W'(LEN)));

    p_strobe_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> err_seen);

    p_flag_hold_r5: assert property (@(posedge clk) disable iff (rst)
        err_seen |=> err_seen);

    p_report_differs_r4: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> (rpt_expected != rpt_actual));

    p_report_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !mismatch |-> ($stable(rpt_cycle) && $stable(rpt_expected) && $stable(rpt_actual)));

    p_strobe_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> (rpt_cycle == CYC_W'(cyc_now - 1'b1)));
endmodule

bind stream_checker stream_checker_sva #(.DATA_W(DATA_W), .LEN(LEN), .CYC_W(CYC_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .done         (done),
    .mismatch     (mismatch),
    .err_seen     (err_seen),
    .cyc_now      (cur_cyc),
    .rpt_cycle    (rpt_cycle),
    .rpt_expected (rpt_expected),
    .rpt_actual   (rpt_actual)
);

// File: tb/test_stream_checker.sv
`timescale 1ns/1ps
module test_stream_checker;
    localparam int DATA_W = 8;
    localparam int LEN    = 10;
    localparam int CYC_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DATA_W-1:0] data_in = '0;
    logic              done, mismatch, err_seen;
    logic [CYC_W-1:0]  rpt_cycle;
    logic [DATA_W-1:0] rpt_expected, rpt_actual;

    int tests = 0;
    int fails = 0;

    // Reference model state
    int exp_vals[$] = '{70, 99, 2, 3, 4, 5, 7, 8, 9, 10};
    int k = 0;
    int m_seen = 0;
    int m_cyc = 0, m_exp = 0, m_act = 0;

    always #4 clk = ~clk;

    stream_checker i_stream_checker (
        .clk(clk), .rst(rst), .data_in(data_in),
        .done(done), .mismatch(mismatch), .err_seen(err_seen),
        .rpt_cycle(rpt_cycle), .rpt_expected(rpt_expected), .rpt_actual(rpt_actual)
    );

    task automatic check(input string req, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at model cycle %0d: actual %0d expected %0d", req, k, act, exp);
        end
    endtask

    task automatic apply_reset(input string req);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check({req, " done"}, done, 0);
        check({req, " mismatch"}, mismatch, 0);
        check({req, " err_seen"}, err_seen, 0);
        check({req, " rpt_cycle"}, rpt_cycle, 0);
        check({req, " rpt_expected"}, rpt_expected, 0);
        check({req, " rpt_actual"}, rpt_actual, 0);
        rst = 1'b0;
        k = 0; m_seen = 0; m_cyc = 0; m_exp = 0; m_act = 0;
    endtask

    // One cycle: drive, check current-cycle done, then registered results.
    task automatic step(input int val);
        int e;
        bit m;
        data_in = DATA_W'(val);
        e = exp_vals[(k < LEN) ? k : LEN - 1];
        m = (val != e);
        check("R6 done", done, (k >= LEN) ? 1 : 0);
        @(negedge clk);
        if (m) begin
            m_seen = 1; m_cyc = k; m_exp = e; m_act = val;
        end
        check((k >= LEN) ? "R7 mismatch" : "R2/R3 mismatch", mismatch, m);
        check("R5 err_seen", err_seen, m_seen);
        check("R4 rpt_cycle", rpt_cycle, m_cyc);
        check((k >= LEN) ? "R7 rpt_expected" : "R2 rpt_expected", rpt_expected, m_exp);
        check("R4 rpt_actual", rpt_actual, m_act);
        k++;
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        apply_reset("R1");

        // Pattern 1: ramp 0..10 then hold 10; mismatches at 0,1,6,7,8,9
        for (int i = 0; i <= 10; i++) step(i);
        for (int i = 0; i < 3; i++) step(10);

        // Pattern 2: every value matches; done still waits for LEN cycles (R6)
        apply_reset("R8");
        for (int i = 0; i < LEN; i++) step(exp_vals[i]);
        for (int i = 0; i < 4; i++) step(10);

        // Pattern 3: reset mid-run, then mismatch only past the list end (R7)
        apply_reset("R8");
        for (int i = 0; i < 4; i++) step(exp_vals[i] ^ 1);
        apply_reset("R8");
        for (int i = 0; i < LEN; i++) step(exp_vals[i]);
        step(9);
        step(10);
        step(11);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule